// File: doc/BRIEF.md
# Clock Source Selection and CPU Prescaler

This block turns register settings into the two clock enables of a small controller core: an internal-clock enable and a CPU-clock enable. Everything runs on one fast reference clock. The oscillator, the secondary clock and the alternate clock reach it as single-cycle tick inputs. It produces its own outputs as single-cycle enable pulses, so no clock is gated or derived. The internal clock comes from one of three sources: the primary oscillator ticks, optionally halved, or the alternate clock when that clock is detected. The CPU enable is the internal enable thinned out by a programmable prescaler.

Software reaches two 8-bit registers through a plain write strobe, a one-bit address and a combinational read. The mode register is at address 0. Bit 5 is the halve control. Bits 4:2 are the prescale field N. Bits 7:6 and 1:0 are plain storage. The control register is at address 1. Bit 7 is plain storage, and bits 6:4 are test bits that read zero. Bit 3 enables reset on halt, bit 2 selects the alternate clock, bit 1 picks the alternate clock for low-power wait, and bit 0 enables low-power wait.

A wait event stops the CPU enable, and an interrupt event ends the wait. In low-power wait the internal enable slows down or moves to the alternate clock. A halt event either requests a reset or shuts the clocking down until reset. The register port has no handshake: a write is taken on every cycle its strobe is high. Control and status pins are plain levels or pulses, so the block has no valid/ready stream and exerts no back-pressure.

Top module: `clkpre_unit`

## Requirements
- R1: After reset the mode register reads E0h and the control register reads 00h. `wfi_active`, `osc_off`, `rst_req` and `alt_active` are 0.
- R2: Control register bits 6:4 always read 0, whatever value was written to them.
- R3: The primary path counts every `osc_tick` since reset. With mode bit 5 set, only the 2nd, 4th, 6th and later even-numbered ticks pass to `int_ce`. With bit 5 clear, every tick passes. Either way the output is in the same cycle as the tick.
- R4: With a latched prescale value N, `cpu_ce` accompanies every (N+1)th `int_ce` pulse while running. N=0 means every pulse.
- R5: A new prescale field is latched only when the prescaler rolls over, so the period in progress is completed at the old value.
- R6: `alt_active` is 1 in a cycle exactly when, in the previous cycle, the alternate-select bit was 1, `alt_present` was 1 and the block was not halted. While `alt_active` is 1, `int_ce` follows `alt_tick`.
- R7: A wait event while running enters wait on the next cycle, and `wfi_active` goes to 1. With low-power wait disabled at entry, `cpu_ce` stays 0 during wait and `int_ce` is unchanged.
- R8: With low-power wait enabled at entry and no alternate clock active, `int_ce` during wait pulses on every 16th `sec_tick`. These are the ticks that complete each group of 16 counted since reset.
- R9: Entering wait with low-power wait and the alternate-for-wait bit both set also sets the alternate-select bit. That bit stays set after the wait ends, until software clears it.
- R10: An interrupt event ends wait on the next cycle. An interrupt event while running has no effect.
- R11: A halt event while running, with reset-on-halt set, gives one `rst_req` pulse on the next cycle and the block keeps running.
- R12: A halt event while running, with reset-on-halt clear, raises `osc_off` on the next cycle. From then until reset, `int_ce` and `cpu_ce` stay 0, and wait and interrupt events are ignored.
- R13: A halt event and a wait event in the same cycle are handled as a halt event alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Primary oscillator tick |
| sec_tick | input | 1 | Secondary clock tick |
| alt_tick | input | 1 | Alternate clock tick |
| alt_present | input | 1 | Alternate clock detected |
| wfi_evt | input | 1 | Wait-for-interrupt event pulse |
| irq_evt | input | 1 | Interrupt event pulse |
| halt_evt | input | 1 | Halt event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 mode, 1 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| int_ce | output | 1 | Internal clock enable pulse |
| cpu_ce | output | 1 | CPU clock enable pulse |
| alt_active | output | 1 | Alternate clock in use |
| wfi_active | output | 1 | Block is in wait |
| osc_off | output | 1 | Clocking shut down by halt |
| rst_req | output | 1 | Reset request pulse |

## Verification
A wrong source-select or halving state shows up as a missing or extra `int_ce` pulse on the very next oscillator tick. A wrong prescaler count or latched divisor shifts `cpu_ce` within one prescale period, which is at most eight internal pulses. A wrong power state or a wrongly kept alternate-select bit shows on `wfi_active`, `osc_off` or `alt_active` one cycle after the event that caused it. A wrong register bit shows in `reg_rdata` in the same cycle it is read.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
  localparam int REG_W   = 8;
  localparam int PRS_W   = 3;
  localparam int PRS_LSB = 2;
  localparam int HALVE_B = 5;
  localparam logic [REG_W-1:0] MODE_RST = 8'hE0;
  localparam int CTL_IRQSEL_B = 7;
  localparam int CTL_SRST_B   = 3;
  localparam int CTL_ALT_B    = 2;
  localparam int CTL_WALT_B   = 1;
  localparam int CTL_LP_B     = 0;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WFI  = 2'd1,
    ST_HALT = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
  import clkpre_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_alt,
  output logic [REG_W-1:0] rdata,
  output logic             halve,
  output logic [PRS_W-1:0] prs,
  output logic             srst_en,
  output logic             alt_sel,
  output logic             wfi_alt,
  output logic             lp_wfi
);
  logic [REG_W-1:0] mode_q;
  logic irqsel_q, srst_q, alt_q, walt_q, lp_q;
  logic wr_mode, wr_ctl;

  assign wr_mode = wr && !addr;
  assign wr_ctl  = wr && addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      irqsel_q <= 1'b0;
      srst_q   <= 1'b0;
      alt_q    <= 1'b0;
      walt_q   <= 1'b0;
      lp_q     <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ctl) begin
        irqsel_q <= wdata[CTL_IRQSEL_B];
        srst_q   <= wdata[CTL_SRST_B];
        walt_q   <= wdata[CTL_WALT_B];
        lp_q     <= wdata[CTL_LP_B];
      end
      alt_q <= (wr_ctl ? wdata[CTL_ALT_B] : alt_q) | set_alt;
    end
  end

  always_comb begin
    if (!addr) begin
      rdata = mode_q;
    end else begin
      rdata = '0;
      rdata[CTL_IRQSEL_B] = irqsel_q;
      rdata[CTL_SRST_B]   = srst_q;
      rdata[CTL_ALT_B]    = alt_q;
      rdata[CTL_WALT_B]   = walt_q;
      rdata[CTL_LP_B]     = lp_q;
    end
  end

  assign halve   = mode_q[HALVE_B];
  assign prs     = mode_q[PRS_LSB +: PRS_W];
  assign srst_en = srst_q;
  assign alt_sel = alt_q;
  assign wfi_alt = walt_q;
  assign lp_wfi  = lp_q;
endmodule

// File: rtl/clkpre_src.sv
module clkpre_src #(
  parameter int LP_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sec_tick,
  input  logic alt_tick,
  input  logic alt_present,
  input  logic halve,
  input  logic alt_sel,
  input  logic halted,
  input  logic lp_path,
  output logic int_ce,
  output logic alt_active
);
  localparam int CW = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(LP_DIV - 1);

  logic          tog_q;
  logic [CW-1:0] slow_cnt_q;
  logic          alt_q;
  logic          prim_ce, slow_ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q      <= 1'b0;
      slow_cnt_q <= '0;
      alt_q      <= 1'b0;
    end else begin
      if (osc_tick) tog_q <= !tog_q;
      if (sec_tick) slow_cnt_q <= (slow_cnt_q == LAST) ? '0 : slow_cnt_q + 1'b1;
      alt_q <= alt_sel && alt_present && !halted;
    end
  end

  assign prim_ce = osc_tick && (!halve || tog_q);
  assign slow_ce = sec_tick && (slow_cnt_q == LAST);

  always_comb begin
    if (halted)       int_ce = 1'b0;
    else if (alt_q)   int_ce = alt_tick;
    else if (lp_path) int_ce = slow_ce;
    else              int_ce = prim_ce;
  end

  assign alt_active = alt_q;
endmodule

// File: rtl/clkpre_prescale.sv
module clkpre_prescale #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_ce,
  input  logic          run,
  input  logic [PW-1:0] prs,
  output logic          cpu_ce
);
  logic [PW-1:0] cnt_q, div_q;
  logic          roll;

  assign roll = (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (run && int_ce) begin
      if (roll) begin
        cnt_q <= '0;
        div_q <= prs;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cpu_ce = run && int_ce && roll;
endmodule

// File: rtl/clkpre_unit.sv
module clkpre_unit
  import clkpre_pkg::*;
#(
  parameter int LP_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             sec_tick,
  input  logic             alt_tick,
  input  logic             alt_present,
  input  logic             wfi_evt,
  input  logic             irq_evt,
  input  logic             halt_evt,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             int_ce,
  output logic             cpu_ce,
  output logic             alt_active,
  output logic             wfi_active,
  output logic             osc_off,
  output logic             rst_req
);
  pwr_state_t       state_q;
  logic             wlp_q, rst_q;
  logic             halve, srst_en, alt_sel, wfi_alt, lp_wfi;
  logic [PRS_W-1:0] prs;
  logic             enter_wfi, halt_go, set_alt, lp_path, halted, running;

  assign running   = (state_q == ST_RUN);
  assign halted    = (state_q == ST_HALT);
  assign halt_go   = running && halt_evt;
  assign enter_wfi = running && wfi_evt && !halt_evt;
  assign set_alt   = enter_wfi && lp_wfi && wfi_alt;
  assign lp_path   = (state_q == ST_WFI) && wlp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      wlp_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= halt_go && srst_en;
      if (enter_wfi) wlp_q <= lp_wfi;
      case (state_q)
        ST_RUN: begin
          if (halt_go && !srst_en) state_q <= ST_HALT;
          else if (enter_wfi)      state_q <= ST_WFI;
        end
        ST_WFI:  if (irq_evt) state_q <= ST_RUN;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  clkpre_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .set_alt(set_alt), .rdata(reg_rdata), .halve(halve), .prs(prs),
    .srst_en(srst_en), .alt_sel(alt_sel), .wfi_alt(wfi_alt), .lp_wfi(lp_wfi)
  );

  clkpre_src #(.LP_DIV(LP_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sec_tick(sec_tick),
    .alt_tick(alt_tick), .alt_present(alt_present), .halve(halve),
    .alt_sel(alt_sel), .halted(halted), .lp_path(lp_path),
    .int_ce(int_ce), .alt_active(alt_active)
  );

  clkpre_prescale #(.PW(PRS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .int_ce(int_ce), .run(running), .prs(prs),
    .cpu_ce(cpu_ce)
  );

  assign wfi_active = (state_q == ST_WFI);
  assign osc_off    = halted;
  assign rst_req    = rst_q;
endmodule

// File: rtl/clkpre_unit_chk.sv
module clkpre_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic alt_present,
  input logic int_ce,
  input logic cpu_ce,
  input logic alt_active,
  input logic wfi_active,
  input logic osc_off,
  input logic rst_req
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R11
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> (!int_ce && !cpu_ce)); // R12
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> osc_off); // R12
  AST_WAIT_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_active |-> !cpu_ce); // R7
  AST_CPU_WITHIN_INT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> int_ce); // R4
  AST_ALT_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alt_active) |-> $past(alt_present)); // R6
  AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wfi_active, osc_off})); // R12
endmodule

bind clkpre_unit clkpre_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alt_present(alt_present), .int_ce(int_ce),
  .cpu_ce(cpu_ce), .alt_active(alt_active), .wfi_active(wfi_active),
  .osc_off(osc_off), .rst_req(rst_req)
);

// File: tb/clkpre_unit_bench.sv
`timescale 1ns/1ps
module clkpre_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 0, sec_tick = 0, alt_tick = 0, alt_present = 0;
  logic wfi_evt = 0, irq_evt = 0, halt_evt = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic int_ce, cpu_ce, alt_active, wfi_active, osc_off, rst_req;

  always #4 clk = ~clk;

  clkpre_unit u_clkpre_unit (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sec_tick(sec_tick),
    .alt_tick(alt_tick), .alt_present(alt_present), .wfi_evt(wfi_evt),
    .irq_evt(irq_evt), .halt_evt(halt_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_ce(int_ce), .cpu_ce(cpu_ce), .alt_active(alt_active),
    .wfi_active(wfi_active), .osc_off(osc_off), .rst_req(rst_req)
  );

  int n_chk = 0, n_fail = 0, cyc_n = 0;
  string cur_req = "R1";

  // behavioural reference state: 0 run, 1 wait, 2 halted
  int m_mode, m_st, m_tog, m_c16, m_pcnt, m_cdiv;
  bit m_irqs, m_srst, m_alts, m_walt, m_lp, m_wlp, m_alt_act, m_rst;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", cur_req, what, act, exp, cyc_n);
    end
  endtask

  task automatic model_reset();
    m_mode = 'hE0; m_st = 0; m_tog = 0; m_c16 = 0; m_pcnt = 0; m_cdiv = 0;
    m_irqs = 0; m_srst = 0; m_alts = 0; m_walt = 0; m_lp = 0; m_wlp = 0;
    m_alt_act = 0; m_rst = 0;
  endtask

  // compare outputs against the model for the current inputs, then advance the model
  task automatic cyc();
    bit prim, slow, e_int, e_cpu, ent, hgo;
    int e_rd, nxt_st;
    #1;
    prim = osc_tick && (!m_mode[5] || m_tog == 1);
    slow = sec_tick && (m_c16 == 15);
    if (m_st == 2) e_int = 0;
    else if (m_alt_act) e_int = alt_tick;
    else if (m_st == 1 && m_wlp) e_int = slow;
    else e_int = prim;
    e_cpu = (m_st == 0) && e_int && (m_pcnt == m_cdiv);
    if (reg_addr == 0) e_rd = m_mode;
    else e_rd = {m_irqs, 3'b000, m_srst, m_alts, m_walt, m_lp};
    chk("int_ce", int_ce, e_int);
    chk("cpu_ce", cpu_ce, e_cpu);
    chk("alt_active", alt_active, m_alt_act);
    chk("wfi_active", wfi_active, m_st == 1);
    chk("osc_off", osc_off, m_st == 2);
    chk("rst_req", rst_req, m_rst);
    chk("reg_rdata", reg_rdata, e_rd);
    // next state
    hgo = (m_st == 0) && halt_evt;
    ent = (m_st == 0) && wfi_evt && !halt_evt;
    nxt_st = m_st;
    if (hgo && !m_srst) nxt_st = 2;
    else if (ent) nxt_st = 1;
    else if (m_st == 1 && irq_evt) nxt_st = 0;
    if (m_st == 0 && e_int) begin
      if (m_pcnt == m_cdiv) begin m_pcnt = 0; m_cdiv = (m_mode >> 2) & 7; end
      else m_pcnt++;
    end
    m_alt_act = m_alts && alt_present && (m_st != 2);
    if (osc_tick) m_tog = 1 - m_tog;
    if (sec_tick) m_c16 = (m_c16 + 1) % 16;
    m_rst = hgo && m_srst;
    if (ent) m_wlp = m_lp;
    begin
      bit set_a;
      set_a = ent && m_lp && m_walt;
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata;
      if (reg_wr && reg_addr == 1) begin
        m_irqs = reg_wdata[7]; m_srst = reg_wdata[3]; m_alts = reg_wdata[2];
        m_walt = reg_wdata[1]; m_lp = reg_wdata[0];
      end
      if (set_a) m_alts = 1;
    end
    m_st = nxt_st;
    @(negedge clk);
    cyc_n++;
  endtask

  task automatic rnd_in();
    osc_tick = ($urandom_range(0, 99) < 55);
    sec_tick = ($urandom_range(0, 99) < 80);
    alt_tick = ($urandom_range(0, 99) < 40);
    reg_addr = $urandom_range(0, 1);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      rnd_in();
      cyc();
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    rnd_in();
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic ev(bit w, bit i, bit h);
    rnd_in();
    wfi_evt = w; irq_evt = i; halt_evt = h;
    cyc();
    wfi_evt = 0; irq_evt = 0; halt_evt = 0;
  endtask

  always @(posedge clk) begin
    if (cyc_n > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc_n);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values on both registers and outputs
    cur_req = "R1";
    reg_addr = 0; cyc();
    reg_addr = 1; cyc();
    run(4);
    // R2: test bits never read back
    cur_req = "R2";
    wr(1, 8'h70); run(4);
    wr(1, 8'hF0); run(4);
    wr(1, 8'h00); run(2);
    // R3: halving on, then off
    cur_req = "R3";
    run(40);
    wr(0, 8'h00); run(40);
    wr(0, 8'h20); run(20);
    // R4 and R5: prescale values, changes mid-period
    cur_req = "R4";
    wr(0, 8'h0C); run(60);
    cur_req = "R5";
    wr(0, 8'h04); run(30);
    wr(0, 8'h1C); run(3);
    wr(0, 8'h08); run(80);
    cur_req = "R4";
    wr(0, 8'h3C); run(120);
    wr(0, 8'h00); run(20);
    // R6: alternate clock follows presence
    cur_req = "R6";
    alt_present = 0;
    wr(1, 8'h04); run(20);
    alt_present = 1; run(30);
    alt_present = 0; run(5);
    alt_present = 1; run(10);
    wr(1, 8'h00); run(10);
    // R7: plain wait, R10: interrupt
    cur_req = "R7";
    wr(0, 8'h08);
    ev(1, 0, 0); run(30);
    cur_req = "R10";
    ev(0, 1, 0); run(10);
    ev(0, 1, 0); run(10);
    // R8: low-power wait on the slow clock
    cur_req = "R8";
    wr(1, 8'h01);
    ev(1, 0, 0); run(100);
    ev(0, 1, 0); run(10);
    // R9: low-power wait on the alternate clock, which stays selected
    cur_req = "R9";
    alt_present = 1;
    wr(1, 8'h03);
    ev(1, 0, 0); run(30);
    ev(0, 1, 0); run(20);
    reg_addr = 1; cyc();
    wr(1, 8'h01); run(10);
    alt_present = 0;
    // R11 and R13: halt with reset enabled, together with a wait event
    cur_req = "R11";
    wr(1, 8'h08);
    ev(0, 0, 1); run(5);
    cur_req = "R13";
    ev(1, 0, 1); run(10);
    // R12 and R13: halt without reset, then ignored events
    cur_req = "R12";
    wr(1, 8'h80); run(5);
    cur_req = "R13";
    ev(1, 0, 1); run(5);
    cur_req = "R12";
    ev(1, 0, 0); run(5);
    ev(0, 1, 0); run(5);
    ev(0, 0, 1); run(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule